// File: doc/BRIEF.md
# Two-Word Key Lock Sequencer

This block guards a bank of control registers behind a two-word software key. It watches every write made to a single key register and drives one `unlocked` level that the surrounding register decoder uses to accept or refuse access to all the other registers in the bank. The block knows nothing about those registers. It only decides whether the bank is open.

Software opens the bank with two consecutive writes to the key register. The first must carry the opening word 0x5F554E4C and the second the closing word 0x4F434B5F. A write of 0x00000000 abandons a partly entered key. A write of 0xFFFFFFFF closes an open bank. A write of any other value between the two key words cancels the attempt. If that stray value is the opening word itself, it counts as a fresh start.

The sequencer has three named states. `S_IDLE` is locked with no key progress, and its step code is 0. `S_ARMED` is locked after the opening word, and its step code is 1. `S_OPEN` is unlocked, and its step code is 2. The transitions are as follows:
- open-key: `S_IDLE` to `S_ARMED` on the opening word.
- re-arm: `S_ARMED` to `S_ARMED` on the opening word.
- accept: `S_ARMED` to `S_OPEN` on the closing word.
- abandon: `S_ARMED` to `S_IDLE` on any other value.
- relock: `S_OPEN` to `S_IDLE` on all-ones.

Every other write, and every cycle without a write, leaves the state as it is.

Top module: `key_lock_seq`

## Requirements
- R1: After reset `unlocked` is 0 and `seq_step` is 0 (code 0 = locked idle, 1 = locked with opening word seen, 2 = open).
- R2: In step 0, a key write of 0x5F554E4C moves `seq_step` to 1 and leaves `unlocked` at 0.
- R3: In step 1, a key write of 0x4F434B5F sets `unlocked` to 1 and `seq_step` to 2. Both outputs change at the clock edge that captures the write.
- R4: In step 0, a key write of any value other than 0x5F554E4C leaves `seq_step` at 0 and `unlocked` at 0. This includes the closing word, zero and all-ones.
- R5: In step 1, a key write of any value other than the two key words returns `seq_step` to 0 with the bank still locked.
- R6: In step 1, a repeated write of 0x5F554E4C keeps `seq_step` at 1.
- R7: A key write of 0x00000000 never changes `unlocked`. When the bank is locked, it leaves `seq_step` at 0.
- R8: When the bank is open, a key write of 0xFFFFFFFF clears `unlocked` and returns `seq_step` to 0 at the next edge.
- R9: When the bank is open, a key write of any value other than 0xFFFFFFFF has no effect. This includes both key words.
- R10: With `key_wr` low, `key_data` is ignored and both outputs hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| key_wr | input | 1 | Write strobe for the key register |
| key_data | input | 32 | Data of the key register write |
| unlocked | output | 1 | High while the register bank is open |
| seq_step | output | 2 | Current sequencer step code |

## Verification
The bench goes after the sequences that a simple enable bit or a careless matcher would get wrong. One is the opening word written twice, where a design that cancels on it would need three writes. Another is a stray word between the two key words, which a matcher that only remembers "opening word seen at some point" would still accept. A third is the closing word written alone, which a design that checks only the last word would accept. While the bank is open, the bench writes zero and both key words to catch a design that relocks on any non-key value. It also drives data with the strobe low, which a design that ignores the strobe would act on. Long random runs, weighted toward the four special values, compare both outputs every cycle against a bench model of the step table.

// File: rtl/klk_pkg.sv
package klk_pkg;

    localparam int unsigned KEY_W = 32;

    typedef enum logic [2:0] {
        WC_OTHER,
        WC_KEY_A,
        WC_KEY_B,
        WC_CLEAR,
        WC_RELOCK
    } word_class_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ARMED = 2'd1,
        S_OPEN  = 2'd2
    } lock_state_e;

endpackage

// File: rtl/klk_word_match.sv
module klk_word_match
    import klk_pkg::*;
#(
    parameter int unsigned      W     = KEY_W,
    parameter logic [W-1:0]     KEY_A = 32'h5F55_4E4C,
    parameter logic [W-1:0]     KEY_B = 32'h4F43_4B5F
) (
    input  logic [W-1:0] data_i,
    output word_class_e  class_o
);

    localparam logic [W-1:0] CLEAR_WORD  = '0;
    localparam logic [W-1:0] RELOCK_WORD = '1;

    logic hit_a, hit_b, hit_clr, hit_rel;

    always_comb begin
        hit_a   = (data_i == KEY_A);
        hit_b   = (data_i == KEY_B);
        hit_clr = (data_i == CLEAR_WORD);
        hit_rel = (data_i == RELOCK_WORD);
    end

    always_comb begin
        if (hit_rel)      class_o = WC_RELOCK;
        else if (hit_clr) class_o = WC_CLEAR;
        else if (hit_b)   class_o = WC_KEY_B;
        else if (hit_a)   class_o = WC_KEY_A;
        else              class_o = WC_OTHER;
    end

endmodule

// File: rtl/klk_fsm.sv
module klk_fsm
    import klk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_i,
    input  word_class_e class_i,
    output lock_state_e state_o
);

    lock_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (wr_i) begin
            unique case (state_q)
                S_IDLE: begin
                    if (class_i == WC_KEY_A) state_d = S_ARMED;    // open-key
                end
                S_ARMED: begin
                    if (class_i == WC_KEY_B)      state_d = S_OPEN;  // accept
                    else if (class_i == WC_KEY_A) state_d = S_ARMED; // re-arm
                    else                          state_d = S_IDLE;  // abandon
                end
                S_OPEN: begin
                    if (class_i == WC_RELOCK) state_d = S_IDLE;    // relock
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    assign state_o = state_q;

endmodule

// File: rtl/key_lock_seq.sv
module key_lock_seq
    import klk_pkg::*;
#(
    parameter int unsigned          W     = KEY_W,
    parameter logic [W-1:0]         KEY_A = 32'h5F55_4E4C,
    parameter logic [W-1:0]         KEY_B = 32'h4F43_4B5F
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         key_wr,
    input  logic [W-1:0] key_data,
    output logic         unlocked,
    output logic [1:0]   seq_step
);

    word_class_e wclass;
    lock_state_e state;

    klk_word_match #(.W(W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_match (
        .data_i  (key_data),
        .class_o (wclass)
    );

    klk_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (key_wr),
        .class_i (wclass),
        .state_o (state)
    );

    always_comb begin
        unlocked = (state == S_OPEN);
        seq_step = state;
    end

endmodule

// File: rtl/klk_checker.sv
module klk_checker #(
    parameter int unsigned      W     = 32,
    parameter logic [W-1:0]     KEY_A = 32'h5F55_4E4C,
    parameter logic [W-1:0]     KEY_B = 32'h4F43_4B5F
) (
    input logic         clk,
    input logic         rst_n,
    input logic         key_wr,
    input logic [W-1:0] key_data,
    input logic         unlocked,
    input logic [1:0]   seq_step
);

    assert_first_key_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_step == 2'd0 && key_wr && key_data == KEY_A) |=> (seq_step == 2'd1 && !unlocked));

    assert_second_key_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_step == 2'd1 && key_wr && key_data == KEY_B) |=> (unlocked && seq_step == 2'd2));

    assert_idle_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_step == 2'd0 && key_wr && key_data != KEY_A) |=> (seq_step == 2'd0 && !unlocked));

    assert_stray_abandons_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_step == 2'd1 && key_wr && key_data != KEY_A && key_data != KEY_B) |=> (seq_step == 2'd0));

    assert_rearm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_step == 2'd1 && key_wr && key_data == KEY_A) |=> (seq_step == 2'd1));

    assert_zero_keeps_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_data == '0) |=> $stable(unlocked));

    assert_relock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && key_wr && key_data == '1) |=> (!unlocked && seq_step == 2'd0));

    assert_open_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && key_wr && key_data != '1) |=> (unlocked && seq_step == 2'd2));

    assert_no_strobe_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_wr) |=> ($stable(seq_step) && $stable(unlocked)));

    assert_open_needs_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> ($past(seq_step) == 2'd1 && $past(key_wr)));

endmodule

bind key_lock_seq klk_checker #(.W(W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_klk_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .key_data (key_data),
    .unlocked (unlocked),
    .seq_step (seq_step)
);

// File: tb/tb_key_lock_seq.sv
`timescale 1ns/1ps
module tb_key_lock_seq;

    localparam logic [31:0] KA = 32'h5F55_4E4C;
    localparam logic [31:0] KB = 32'h4F43_4B5F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        key_wr = 1'b0;
    logic [31:0] key_data = '0;
    logic        unlocked;
    logic [1:0]  seq_step;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    bit          done = 0;
    logic [1:0]  model = 2'd0;

    always #5 clk = ~clk;

    key_lock_seq dut (
        .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_data(key_data),
        .unlocked(unlocked), .seq_step(seq_step)
    );

    function automatic logic [1:0] next_step(logic [1:0] s, logic wr, logic [31:0] d);
        if (!wr) return s;
        case (s)
            2'd0: return (d == KA) ? 2'd1 : 2'd0;
            2'd1: return (d == KB) ? 2'd2 : ((d == KA) ? 2'd1 : 2'd0);
            2'd2: return (d == 32'hFFFF_FFFF) ? 2'd0 : 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    function automatic string req_of(logic [1:0] s, logic wr, logic [31:0] d);
        if (!wr) return "R10";
        if (s == 2'd2) return (d == 32'hFFFF_FFFF) ? "R8" : ((d == 0) ? "R7" : "R9");
        if (d == 0) return "R7";
        if (s == 2'd0) return (d == KA) ? "R2" : "R4";
        if (d == KB) return "R3";
        if (d == KA) return "R6";
        return "R5";
    endfunction

    task automatic check(string req);
        n_cmp++;
        if (seq_step !== model || unlocked !== (model == 2'd2)) begin
            n_bad++;
            $display("FAIL %s: step=%0d unlocked=%0b expected step=%0d unlocked=%0b",
                     req, seq_step, unlocked, model, (model == 2'd2));
        end
    endtask

    task automatic step(logic wr, logic [31:0] d);
        string r;
        @(negedge clk);
        key_wr = wr;
        key_data = d;
        r = req_of(model, wr, d);
        model = next_step(model, wr, d);
        @(posedge clk);
        #2;
        check(r);
    endtask

    function automatic logic [31:0] pick_word();
        case ($urandom % 6)
            0: return KA;
            1: return KB;
            2: return 32'h0;
            3: return 32'hFFFF_FFFF;
            default: return $urandom;
        endcase
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #2;
        model = 2'd0;
        check("R1");
        @(negedge clk);
        rst_n = 1'b1;

        // directed sequences
        step(1, KA); step(1, KB);                 // R2 then R3: open
        step(1, 32'h0);                           // R7 while open
        step(1, KA); step(1, KB); step(1, 32'h1234_5678); // R9 keys ignored when open
        step(0, 32'hFFFF_FFFF);                   // R10 strobe low, no relock
        step(1, 32'hFFFF_FFFF);                   // R8 relock
        step(1, KB);                              // R4 closing word alone
        step(1, 32'hFFFF_FFFF);                   // R4 all-ones while locked
        step(1, KA); step(1, KA); step(1, KB);    // R6 re-arm then R3
        step(1, 32'hFFFF_FFFF);                   // R8
        step(1, KA); step(1, 32'hDEAD_BEEF); step(1, KB); // R5 stray cancels
        step(1, KA); step(1, 32'h0); step(1, KB); // R7 zero cancels
        step(1, KA); step(0, KB); step(1, KB);    // R10 strobe low keeps step 1

        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 4) != 0, pick_word());
        end
        done = 1;
        summary();
    end

    initial begin
        #(200_000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            summary();
        end
    end

endmodule